// File: doc/BRIEF.md
# Multicast hash filter table

This block keeps a 64-bit hash table that an Ethernet receiver uses to accept or reject multicast destination addresses. Software hands it a list of 48-bit group addresses as a byte stream. Each load first empties the table. For every complete 6-byte address the block runs a CRC-32 and sets one table bit chosen by part of that CRC.

The receive path asks about a destination address through a separate lookup port. It gets back the table bit that the same hash selects. The list is delivered one byte per cycle through a valid/ready pair. A lookup that arrives while a load is under way waits until the load has finished.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, load_ready, load_done and result_valid are 0, lookup_ready is 1, and every lookup returns result_hit = 0.
- R2: Accepting load_start (block idle) clears all 64 table bits before any bit of the new list is set; a load with count 0 leaves the table empty.
- R3: The number of addresses entered is load_count divided by 6 (integer division), capped at 64; the load consumes exactly load_count bytes.
- R4: The hash of an address is a CRC-32 with polynomial 0x04C11DB7, start value 0xFFFFFFFF and no final inversion. The CRC register shifts towards its MSB, and each byte enters least significant bit first. Bytes enter in the order lookup_addr[47:40] first and [7:0] last, which on the load stream is the order of arrival. Bits 7:2 of the CRC form the 6-bit index.
- R5: Each entered address sets table bit number index, which is bit index&7 of byte index>>3. Bits set by earlier addresses of the same load stay set.
- R6: A lookup is accepted when lookup_valid and lookup_ready are both high. In the next cycle result_valid is 1 for one cycle, and result_hit equals the table bit at the index of lookup_addr.
- R7: From the cycle after an accepted load_start with a non-zero count, load_ready stays 1 until the last byte is accepted. A byte is taken only on a cycle with load_valid and load_ready both high.
- R8: Bytes past the capped entry count are consumed but change no table bit. This covers the remainder bytes of an incomplete address and the addresses after the 64th.
- R9: While a load is running, lookup_ready is 0 and no result is produced. A load_start seen during a running load has no effect.
- R10: load_done is 1 for one cycle, in the cycle after the last byte is accepted, or in the cycle after load_start when the count is 0. At that point the table already holds the complete list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_start | input | 1 | Begin a list load (taken when idle) |
| load_count | input | 16 | Number of list bytes that follow |
| load_data | input | 8 | List byte |
| load_valid | input | 1 | load_data holds a byte |
| load_ready | output | 1 | Block takes a byte this cycle |
| load_done | output | 1 | One-cycle pulse when the load is complete |
| lookup_valid | input | 1 | Lookup request |
| lookup_addr | input | 48 | Destination address to test |
| lookup_ready | output | 1 | Lookup accepted this cycle |
| result_valid | output | 1 | result_hit is valid |
| result_hit | output | 1 | Table bit for the looked-up address |

## Verification
The bench builds the block with its defaults: a 64-bit table, a cap of 64 entries, 6-byte addresses and a 16-bit count. These defaults let a 420-byte list exceed the cap, so the 65th and later addresses can be shown to be dropped. An 11-byte list exercises a partial trailing address. Because the expected hit is computed per address in the bench, a choice of a second address with a different index makes each dropped byte observable as a lookup miss.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_st_e;
endpackage

// File: rtl/mhf_crc_step.sv
module mhf_crc_step
    import mhf_pkg::*;
(
    input  logic [31:0] crc_i,
    input  logic [7:0]  data_i,
    output logic [31:0] crc_o
);
    logic [31:0] acc;
    logic        fb;

    // Byte-serial update: register shifts up, data enters LSB first
    always_comb begin
        acc = crc_i;
        fb  = 1'b0;
        for (int i = 0; i < 8; i++) begin
            fb  = acc[31] ^ data_i[i];
            acc = {acc[30:0], 1'b0};
            if (fb) acc = acc ^ CRC_POLY;
        end
        crc_o = acc;
    end
endmodule

// File: rtl/mhf_lookup_hash.sv
module mhf_lookup_hash
    import mhf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 6,
    localparam int ADDR_W    = 8 * ADDR_BYTES
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  idx_o
);
    logic [31:0] chain [0:ADDR_BYTES];

    assign chain[0] = CRC_INIT;

    // One CRC stage per address byte, first wire byte in the top bits
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_stage
        mhf_crc_step u_step (
            .crc_i  (chain[g]),
            .data_i (addr_i[ADDR_W-1-8*g -: 8]),
            .crc_o  (chain[g+1])
        );
    end

    assign idx_o = chain[ADDR_BYTES][IDX_W+1:2];
endmodule

// File: rtl/mhf_load_seq.sv
module mhf_load_seq
    import mhf_pkg::*;
#(
    parameter int ADDR_BYTES  = 6,
    parameter int MAX_ENTRIES = 64,
    parameter int CNT_W       = 16,
    parameter int IDX_W       = 6,
    localparam int POS_W      = $clog2(ADDR_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [7:0]       data_i,
    input  logic             valid_i,
    output logic             ready_o,
    output logic             done_o,
    output logic             busy_o,
    output logic             clear_o,
    output logic             set_o,
    output logic [IDX_W-1:0] set_idx_o
);
    localparam logic [CNT_W-1:0] NBYTES   = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] CAP      = CNT_W'(MAX_ENTRIES);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(ADDR_BYTES - 1);

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] rem;
        logic [CNT_W-1:0] useful;
        logic [POS_W-1:0] pos;
        logic [31:0]      crc;
        logic             done;
    } seq_t;

    seq_t        s_d, s_q;
    logic [31:0] crc_next;
    logic [CNT_W-1:0] entries;

    mhf_crc_step u_crc (
        .crc_i  (s_q.crc),
        .data_i (data_i),
        .crc_o  (crc_next)
    );

    always_comb begin
        entries = count_i / NBYTES;
        if (entries > CAP) entries = CAP;
    end

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        clear_o   = 1'b0;
        set_o     = 1'b0;
        set_idx_o = crc_next[IDX_W+1:2];
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (start_i) begin
                    clear_o    = 1'b1;
                    s_d.rem    = count_i;
                    s_d.useful = CNT_W'(entries * NBYTES);
                    s_d.pos    = '0;
                    s_d.crc    = CRC_INIT;
                    if (count_i == '0) s_d.done = 1'b1;
                    else               s_d.st   = SEQ_RUN;
                end
            end
            SEQ_RUN: begin
                if (valid_i) begin
                    s_d.rem = s_q.rem - 1'b1;
                    if (s_q.useful != '0) begin
                        s_d.useful = s_q.useful - 1'b1;
                        if (s_q.pos == LAST_POS) begin
                            set_o   = 1'b1;
                            s_d.pos = '0;
                            s_d.crc = CRC_INIT;
                        end else begin
                            s_d.pos = s_q.pos + 1'b1;
                            s_d.crc = crc_next;
                        end
                    end
                    if (s_q.rem == CNT_W'(1)) begin
                        s_d.st   = SEQ_IDLE;
                        s_d.done = 1'b1;
                    end
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st     <= SEQ_IDLE;
            s_q.rem    <= '0;
            s_q.useful <= '0;
            s_q.pos    <= '0;
            s_q.crc    <= CRC_INIT;
            s_q.done   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready_o = (s_q.st == SEQ_RUN);
    assign busy_o  = (s_q.st == SEQ_RUN);
    assign done_o  = s_q.done;
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
    import mhf_pkg::*;
#(
    parameter int TABLE_BITS  = 64,
    parameter int MAX_ENTRIES = 64,
    parameter int ADDR_BYTES  = 6,
    parameter int CNT_W       = 16,
    localparam int IDX_W      = $clog2(TABLE_BITS),
    localparam int ADDR_W     = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_start,
    input  logic [CNT_W-1:0]  load_count,
    input  logic [7:0]        load_data,
    input  logic              load_valid,
    output logic              load_ready,
    output logic              load_done,
    input  logic              lookup_valid,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              lookup_ready,
    output logic              result_valid,
    output logic              result_hit
);
    typedef struct packed {
        logic [TABLE_BITS-1:0] tbl;
        logic                  rv;
        logic                  hit;
    } top_t;

    top_t             t_d, t_q;
    logic             busy, clr, set_en;
    logic [IDX_W-1:0] set_idx, look_idx;

    mhf_load_seq #(
        .ADDR_BYTES  (ADDR_BYTES),
        .MAX_ENTRIES (MAX_ENTRIES),
        .CNT_W       (CNT_W),
        .IDX_W       (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (load_start),
        .count_i   (load_count),
        .data_i    (load_data),
        .valid_i   (load_valid),
        .ready_o   (load_ready),
        .done_o    (load_done),
        .busy_o    (busy),
        .clear_o   (clr),
        .set_o     (set_en),
        .set_idx_o (set_idx)
    );

    mhf_lookup_hash #(
        .ADDR_BYTES (ADDR_BYTES),
        .IDX_W      (IDX_W)
    ) u_hash (
        .addr_i (lookup_addr),
        .idx_o  (look_idx)
    );

    assign lookup_ready = !busy && !load_start;

    always_comb begin
        t_d    = t_q;
        t_d.rv = lookup_valid && lookup_ready;
        if (lookup_valid && lookup_ready) t_d.hit = t_q.tbl[look_idx];
        if (clr)         t_d.tbl = '0;
        else if (set_en) t_d.tbl[set_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign result_valid = t_q.rv;
    assign result_hit   = t_q.hit;
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker (
    input logic clk,
    input logic rst_n,
    input logic load_start,
    input logic load_ready,
    input logic load_done,
    input logic lookup_valid,
    input logic lookup_ready,
    input logic result_valid
);
    // R9
    stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_ready |-> !lookup_ready);

    // R6
    result_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(lookup_valid && lookup_ready));

    // R7
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_ready) |-> $past(load_start));

    // R10
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_ready) |-> load_done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !load_ready);
endmodule

bind mcast_hash_filter mhf_checker u_mhf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_start   (load_start),
    .load_ready   (load_ready),
    .load_done    (load_done),
    .lookup_valid (lookup_valid),
    .lookup_ready (lookup_ready),
    .result_valid (result_valid)
);

// File: tb/mcast_hash_filter_tb_top.sv
module mcast_hash_filter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_start = 1'b0;
    logic [15:0] load_count = '0;
    logic [7:0]  load_data = '0;
    logic        load_valid = 1'b0;
    logic        load_ready, load_done;
    logic        lookup_valid = 1'b0;
    logic [47:0] lookup_addr = '0;
    logic        lookup_ready, result_valid, result_hit;

    int errors = 0;
    int checks = 0;
    logic [63:0] mdl = '0;
    logic [7:0]  stream [0:511];

    always #(CLK_PERIOD/2) clk = ~clk;

    mcast_hash_filter dut_i (
        .clk(clk), .rst_n(rst_n),
        .load_start(load_start), .load_count(load_count),
        .load_data(load_data), .load_valid(load_valid),
        .load_ready(load_ready), .load_done(load_done),
        .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
        .lookup_ready(lookup_ready), .result_valid(result_valid),
        .result_hit(result_hit)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model of the hash (R4)
    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b = a[47-8*i -: 8];
            for (int j = 0; j < 8; j++) begin
                logic cy = c[31] ^ b[j];
                c = c << 1;
                if (cy) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c[7:2];
    endfunction

    function automatic logic [47:0] gen_addr(input int k);
        return (48'h0123_4567_89AB * 48'(k + 7)) ^ 48'(k) ^ 48'h0100_0000_0000;
    endfunction

    function automatic logic [47:0] other_addr(input logic [47:0] a, input int from);
        for (int k = from; k < from + 200; k++)
            if (hidx(gen_addr(k)) != hidx(a)) return gen_addr(k);
        return gen_addr(from);
    endfunction

    task automatic put_addr(input int slot, input logic [47:0] a);
        for (int i = 0; i < 6; i++) stream[slot*6+i] = a[47-8*i -: 8];
    endtask

    // Model of a load (R2, R3, R5, R8)
    task automatic model_load(input int count);
        int ent = count / 6;
        if (ent > 64) ent = 64;
        mdl = '0;
        for (int e = 0; e < ent; e++) begin
            logic [47:0] a;
            for (int i = 0; i < 6; i++) a[47-8*i -: 8] = stream[e*6+i];
            mdl[hidx(a)] = 1'b1;
        end
    endtask

    task automatic run_load(input string tag, input int count, input bit gaps, input bit poke);
        int  i = 0;
        int  cyc = 0;
        bit  early = 0;
        bit  stall_bad = 0;
        logic v;
        @(negedge clk);
        load_start = 1'b1;
        load_count = 16'(count);
        @(negedge clk);
        load_start = 1'b0;
        model_load(count);
        if (count == 0) begin
            check({tag, " R10 done after zero count"}, 64'(load_done), 64'd1);
            return;
        end
        check({tag, " R7 ready after start"}, 64'(load_ready), 64'd1);
        while (i < count) begin
            v = !(gaps && (cyc % 2 == 1));
            load_valid = v;
            load_data  = stream[i];
            if (poke) begin
                lookup_valid = 1'b1;
                lookup_addr  = gen_addr(3);
                load_start   = (cyc == 5);
                load_count   = 16'd0;
            end
            @(negedge clk);
            if (v) i++;
            cyc++;
            if (i < count) begin
                if (load_done !== 1'b0 || load_ready !== 1'b1) early = 1;
                if (poke && (lookup_ready !== 1'b0 || result_valid !== 1'b0)) stall_bad = 1;
            end
        end
        load_valid   = 1'b0;
        lookup_valid = 1'b0;
        load_start   = 1'b0;
        check({tag, " R7 no early done, ready held"}, 64'(early), 64'd0);
        if (poke) check({tag, " R9 lookup stalled"}, 64'(stall_bad), 64'd0);
        check({tag, " R10 done after last byte"}, 64'(load_done), 64'd1);
        check({tag, " R3 all bytes consumed"}, 64'(load_ready), 64'd0);
        @(negedge clk);
        check({tag, " R10 done one cycle"}, 64'(load_done), 64'd0);
    endtask

    task automatic do_lookup(input string tag, input logic [47:0] a);
        @(negedge clk);
        lookup_valid = 1'b1;
        lookup_addr  = a;
        while (lookup_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        lookup_valid = 1'b0;
        check({tag, " R6 result_valid"}, 64'(result_valid), 64'd1);
        check({tag, " R6 hit"}, 64'(result_hit), 64'(mdl[hidx(a)]));
    endtask

    task automatic t_reset();
        check("R1 load_ready", 64'(load_ready), 64'd0);
        check("R1 load_done", 64'(load_done), 64'd0);
        check("R1 result_valid", 64'(result_valid), 64'd0);
        check("R1 lookup_ready", 64'(lookup_ready), 64'd1);
        do_lookup("R1 empty", gen_addr(1));
        check("R1 empty table miss", 64'(result_hit), 64'd0);
    endtask

    task automatic t_basic();
        for (int k = 0; k < 3; k++) put_addr(k, gen_addr(10 + k));
        run_load("basic", 18, 0, 0);
        for (int k = 0; k < 3; k++) begin
            do_lookup("R4 R5 loaded", gen_addr(10 + k));
            check("R5 loaded address hits", 64'(result_hit), 64'd1);
        end
        do_lookup("R4 absent", gen_addr(40));
    endtask

    task automatic t_gaps();
        put_addr(0, gen_addr(20));
        put_addr(1, gen_addr(21));
        run_load("gaps", 12, 1, 0);
        do_lookup("R7 gap load", gen_addr(20));
        do_lookup("R7 gap load", gen_addr(21));
        check("R7 gapped bytes taken", 64'(result_hit), 64'd1);
    endtask

    task automatic t_clear();
        logic [47:0] c = other_addr(gen_addr(20), 60);
        c = (hidx(c) == hidx(gen_addr(21))) ? other_addr(gen_addr(21), 300) : c;
        put_addr(0, c);
        run_load("clear", 6, 0, 0);
        do_lookup("R2 old entry", gen_addr(20));
        check("R2 old entry cleared", 64'(result_hit), 64'(hidx(gen_addr(20)) == hidx(c)));
        do_lookup("R2 new entry", c);
    endtask

    task automatic t_remainder();
        logic [47:0] a = gen_addr(30);
        logic [47:0] b = other_addr(a, 31);
        put_addr(0, a);
        put_addr(1, b);
        run_load("remainder", 11, 0, 0);
        do_lookup("R3 first entry", a);
        do_lookup("R8 partial", b);
        check("R8 partial address ignored", 64'(result_hit), 64'd0);
    endtask

    task automatic t_cap();
        logic [47:0] a = gen_addr(50);
        logic [47:0] b = other_addr(a, 51);
        for (int k = 0; k < 64; k++) put_addr(k, a);
        for (int k = 64; k < 70; k++) put_addr(k, b);
        run_load("cap", 420, 0, 0);
        do_lookup("R3 capped", a);
        check("R3 entry within cap", 64'(result_hit), 64'd1);
        do_lookup("R8 beyond cap", b);
        check("R8 entries beyond cap ignored", 64'(result_hit), 64'd0);
    endtask

    task automatic t_stall();
        put_addr(0, gen_addr(3));
        put_addr(1, gen_addr(4));
        run_load("stall", 12, 0, 1);
        do_lookup("R9 start ignored", gen_addr(3));
        check("R9 table kept after busy start", 64'(result_hit), 64'd1);
    endtask

    task automatic t_zero();
        run_load("zero", 0, 0, 0);
        do_lookup("R2 zero count", gen_addr(4));
        check("R2 zero count empties table", 64'(result_hit), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_gaps();
        t_clear();
        t_remainder();
        t_cap();
        t_stall();
        t_zero();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule